// File: doc/BRIEF.md
# Transport Stream Packet Synchronizer

The synchronizer takes a byte-wide transport stream and finds the packet boundaries in it. It watches every valid input byte for the sync value 0x47. It then checks that the value comes back at a fixed pitch: every 188 bytes for plain packets, or every 204 bytes when each packet carries 16 trailing error-correction bytes. It decides for itself which of the two pitches the stream uses. It declares lock only after a run of consecutive sync hits at that pitch. The run length is a parameter, meant to be set between 3 and 5.

While locked, every input byte is passed on one clock later. Each byte comes with a start-of-packet flag, its index inside the packet, the lock flag and the detected packet length, so parsers downstream can start work as soon as lock is reached. A short run of corrupted sync bytes is ridden through on the established timing. A longer run drops lock, and the search starts again. Bytes received while unlocked are never marked valid at the output.

Top module: `ts_pkt_sync`

## Requirements
- R1: After a cycle with `rst_n` low, `out_locked` and `out_valid` are 0.
- R2: A 0x47 byte found while searching becomes a candidate packet start. If the input byte 188 valid bytes later is also 0x47, the packet length becomes 188 (`out_len` = 188).
- R3: If the byte 188 valid bytes after the candidate is not 0x47 but the byte 204 valid bytes after it is, the packet length becomes 204 (`out_len` = 204).
- R4: If neither the byte at distance 188 nor the byte at distance 204 is 0x47, the candidate is dropped and the search resumes at the next 0x47.
- R5: Lock is declared on the LOCK_HITS-th consecutive 0x47 at the detected pitch, counting the candidate as the first. That sync byte is the first forwarded byte: `out_valid`=1, `out_sop`=1, `out_idx`=0, and `out_locked` rises in the same cycle.
- R6: Before lock, if the byte at an expected sync position is not 0x47, the hit run is discarded and the search starts over.
- R7: While unlocked, `out_valid` stays 0 for every input byte, including the byte that causes lock to be lost.
- R8: While locked, each valid input byte appears on `out_byte` one clock later with `out_valid`=1. `out_idx` runs from 0 at the packet start to length−1 and then wraps to 0, and `out_sop` is 1 exactly when `out_idx` is 0.
- R9: While locked, fewer than MISS_LIMIT consecutive missing sync bytes at expected positions keep lock and the packet timing, and those bytes are still flagged with `out_sop`=1. A correct sync byte clears the miss run.
- R10: The MISS_LIMIT-th consecutive missing sync byte drops `out_locked` in the cycle after it arrives, and the search restarts.
- R11: A cycle with `in_valid` low changes no state: in the next cycle `out_valid` is 0 and `out_locked` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_byte` holds a stream byte this cycle |
| in_byte | input | 8 | Incoming stream byte |
| out_valid | output | 1 | Forwarded byte is present (only while locked) |
| out_byte | output | 8 | Forwarded stream byte |
| out_sop | output | 1 | Forwarded byte is the first of its packet |
| out_idx | output | POS_W (8) | Index of the forwarded byte inside its packet |
| out_locked | output | 1 | Packet timing is locked |
| out_len | output | POS_W (8) | Detected packet length, 188 or 204; meaningful while locked |

## Verification
The bench targets the exact byte on which lock is declared, since a hit counter that is off by one would lock one packet early or late. It also targets the fallback from the 188 check to the 204 check: a design that gave up after 188 would never lock on error-protected packets. A stray 0x47 with no partner at either pitch must release the search, or the true stream would be missed. A single corrupted sync while locked must not drop lock, but MISS_LIMIT of them in a row must, and the byte that drops lock must not be forwarded. All of this runs with random idle gaps on `in_valid`, so a design that counted clock cycles instead of valid bytes would drift off the packet grid.

// File: rtl/tsf_pkg.sv
// Shared types for the transport stream packet synchronizer.
// Assumes nothing beyond the standard 2-bit state encoding below.
package tsf_pkg;
    // Synchronizer search / lock states
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,   // scanning for any sync byte
        ST_PROBE   = 2'd1,   // candidate found, measuring the pitch
        ST_CONFIRM = 2'd2,   // pitch known, collecting consecutive hits
        ST_TRACK   = 2'd3    // locked, forwarding bytes
    } sync_state_t;
endpackage

// File: rtl/tsf_pos_ctr.sv
// Byte position counter inside the candidate or locked packet.
// Restarts at 1 when a sync byte is taken as index 0, counts freely while
// the pitch is probed, and wraps at the packet length once it is known.
// Assumes the controller only steps it on valid input bytes.
module tsf_pos_ctr #(
    parameter int unsigned MAX_POS = 204,
    localparam int unsigned W = $clog2(MAX_POS + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         restart,
    input  logic         wrap_en,
    input  logic [W-1:0] wrap_at,
    output logic [W-1:0] pos
);
    // Advance, restart or wrap the position on each stepped byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (step) begin
            if (restart) begin
                pos <= W'(1);
            end else if (wrap_en && (pos == wrap_at)) begin
                pos <= '0;
            end else begin
                pos <= pos + W'(1);
            end
        end
    end

    // The probe gives up at MAX_POS, so the counter never passes it
    assert_pos_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= W'(MAX_POS));
endmodule

// File: rtl/tsf_run_ctr.sv
// Counter for a run of consecutive events (sync hits or sync misses).
// Can be cleared, loaded with a start value, or incremented. It relies on
// the controller acting on the run before it reaches LIMIT.
module tsf_run_ctr #(
    parameter int unsigned LIMIT = 3,
    localparam int unsigned W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Clear has priority over load, load over increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end

    // The controller must leave the run before it would pass LIMIT (R5, R10)
    assert_run_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !load) |-> (cnt < W'(LIMIT)));
endmodule

// File: rtl/tsf_ctrl.sv
// Search and lock controller. It decides, per valid byte, whether the byte
// starts a candidate, confirms the pitch, adds a hit or miss, or is
// forwarded. It also holds the detected length (0: short, 1: long).
// Assumes pos, hits and misses come from the counters it drives.
module tsf_ctrl
    import tsf_pkg::*;
#(
    parameter int unsigned LEN_SHORT  = 188,
    parameter int unsigned LEN_LONG   = 204,
    parameter int unsigned LOCK_HITS  = 3,
    parameter int unsigned MISS_LIMIT = 3,
    localparam int unsigned POS_W  = $clog2(LEN_LONG + 1),
    localparam int unsigned HIT_W  = $clog2(LOCK_HITS + 1),
    localparam int unsigned MISS_W = $clog2(MISS_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              is_sync,
    input  logic [POS_W-1:0]  pos,
    input  logic [HIT_W-1:0]  hits,
    input  logic [MISS_W-1:0] misses,
    output logic              pos_step,
    output logic              pos_restart,
    output logic              pos_wrap_en,
    output logic              hit_clr,
    output logic              hit_load,
    output logic              hit_inc,
    output logic              miss_clr,
    output logic              miss_inc,
    output logic              fwd,
    output logic              track_nxt,
    output logic              len_long_q,
    output logic              len_long_nxt
);
    sync_state_t st_q, st_nxt;
    logic        at_head;

    assign at_head     = (pos == '0);
    assign pos_wrap_en = (st_q == ST_CONFIRM) || (st_q == ST_TRACK);
    assign track_nxt   = (st_nxt == ST_TRACK);
    assign hit_clr     = (st_nxt == ST_HUNT);

    // Next-state and counter control for the current input byte
    always_comb begin
        st_nxt       = st_q;
        len_long_nxt = len_long_q;
        pos_step     = 1'b0;
        pos_restart  = 1'b0;
        hit_load     = 1'b0;
        hit_inc      = 1'b0;
        miss_clr     = 1'b0;
        miss_inc     = 1'b0;
        fwd          = 1'b0;
        if (in_valid) begin
            unique case (st_q)
                ST_HUNT: begin
                    if (is_sync) begin
                        st_nxt      = ST_PROBE;
                        pos_step    = 1'b1;
                        pos_restart = 1'b1;
                    end
                end
                ST_PROBE: begin
                    pos_step = 1'b1;
                    if ((pos == POS_W'(LEN_SHORT)) && is_sync) begin
                        st_nxt       = ST_CONFIRM;
                        len_long_nxt = 1'b0;
                        pos_restart  = 1'b1;
                        hit_load     = 1'b1;
                    end else if (pos == POS_W'(LEN_LONG)) begin
                        if (is_sync) begin
                            st_nxt       = ST_CONFIRM;
                            len_long_nxt = 1'b1;
                            pos_restart  = 1'b1;
                            hit_load     = 1'b1;
                        end else begin
                            st_nxt   = ST_HUNT;
                            pos_step = 1'b0;
                        end
                    end
                end
                ST_CONFIRM: begin
                    pos_step = 1'b1;
                    if (at_head) begin
                        if (is_sync) begin
                            hit_inc = 1'b1;
                            if (hits == HIT_W'(LOCK_HITS - 1)) begin
                                st_nxt   = ST_TRACK;
                                miss_clr = 1'b1;
                                fwd      = 1'b1;
                            end
                        end else begin
                            st_nxt = ST_HUNT;
                        end
                    end
                end
                ST_TRACK: begin
                    pos_step = 1'b1;
                    fwd      = 1'b1;
                    if (at_head) begin
                        if (is_sync) begin
                            miss_clr = 1'b1;
                        end else if (misses == MISS_W'(MISS_LIMIT - 1)) begin
                            st_nxt = ST_HUNT;
                            fwd    = 1'b0;
                        end else begin
                            miss_inc = 1'b1;
                        end
                    end
                end
                default: st_nxt = ST_HUNT;
            endcase
        end
    end

    // State and detected length registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_HUNT;
            len_long_q <= 1'b0;
        end else begin
            st_q       <= st_nxt;
            len_long_q <= len_long_nxt;
        end
    end

    // While confirming, the hit run holds the candidate and probe hits but is short of lock
    assert_confirm_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONFIRM) |-> ((hits >= HIT_W'(2)) && (hits < HIT_W'(LOCK_HITS))));
    // While locked, the miss run never reaches the drop limit
    assert_track_misses_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRACK) |-> (misses < MISS_W'(MISS_LIMIT)));
    // A byte that fails the probe at the long pitch sends the search back to hunting
    assert_probe_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (st_q == ST_PROBE) && (pos == POS_W'(LEN_LONG)) && !is_sync)
        |=> (st_q == ST_HUNT));
endmodule

// File: rtl/tsf_out_stage.sv
// Registered output stage: captures the forwarded byte with its packet
// position, the lock flag and the packet length. Assumes fwd is only raised
// for bytes that belong to a locked stream.
module tsf_out_stage #(
    parameter int unsigned LEN_SHORT = 188,
    parameter int unsigned LEN_LONG  = 204,
    parameter logic [7:0]  SYNC_VAL  = 8'h47,
    localparam int unsigned POS_W = $clog2(LEN_LONG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd,
    input  logic [7:0]       byte_in,
    input  logic [POS_W-1:0] pos,
    input  logic             track_nxt,
    input  logic             len_long_nxt,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_sop,
    output logic [POS_W-1:0] out_idx,
    output logic             out_locked,
    output logic [POS_W-1:0] out_len
);
    // Capture the forwarded byte and the status flags each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_byte   <= '0;
            out_sop    <= 1'b0;
            out_idx    <= '0;
            out_locked <= 1'b0;
            out_len    <= POS_W'(LEN_SHORT);
        end else begin
            out_valid  <= fwd;
            out_locked <= track_nxt;
            out_len    <= len_long_nxt ? POS_W'(LEN_LONG) : POS_W'(LEN_SHORT);
            if (fwd) begin
                out_byte <= byte_in;
                out_sop  <= (pos == '0);
                out_idx  <= pos;
            end
        end
    end

    // No byte leaves the block unless lock is held
    assert_fwd_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_locked);
    // Lock is first shown on a forwarded sync byte at index 0
    assert_lock_on_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_locked) |-> (out_valid && out_sop && (out_byte == SYNC_VAL)));
    // The index stays inside the detected packet
    assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx < out_len));
    // The length cannot change while lock is held
    assert_len_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_locked && $past(out_locked)) |-> $stable(out_len));
endmodule

// File: rtl/ts_pkt_sync.sv
// Transport stream packet synchronizer, top level.
// Finds 0x47 sync bytes, measures a 188- or 204-byte pitch, locks after
// LOCK_HITS consecutive hits and forwards bytes with packet framing until
// MISS_LIMIT consecutive sync misses. Assumes byte-aligned input; one byte
// per cycle with in_valid high.
module ts_pkt_sync #(
    parameter int unsigned LEN_SHORT  = 188,
    parameter int unsigned LEN_LONG   = 204,
    parameter logic [7:0]  SYNC_VAL   = 8'h47,
    parameter int unsigned LOCK_HITS  = 3,
    parameter int unsigned MISS_LIMIT = 3,
    localparam int unsigned POS_W = $clog2(LEN_LONG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_sop,
    output logic [POS_W-1:0] out_idx,
    output logic             out_locked,
    output logic [POS_W-1:0] out_len
);
    localparam int unsigned HIT_W  = $clog2(LOCK_HITS + 1);
    localparam int unsigned MISS_W = $clog2(MISS_LIMIT + 1);

    logic              is_sync;
    logic [POS_W-1:0]  pos;
    logic [HIT_W-1:0]  hits;
    logic [MISS_W-1:0] misses;
    logic pos_step, pos_restart, pos_wrap_en;
    logic hit_clr, hit_load, hit_inc, miss_clr, miss_inc;
    logic fwd, track_nxt, len_long_q, len_long_nxt;
    logic [POS_W-1:0] wrap_at;

    assign is_sync = (in_byte == SYNC_VAL);
    assign wrap_at = len_long_q ? POS_W'(LEN_LONG - 1) : POS_W'(LEN_SHORT - 1);

    tsf_ctrl #(
        .LEN_SHORT (LEN_SHORT),
        .LEN_LONG  (LEN_LONG),
        .LOCK_HITS (LOCK_HITS),
        .MISS_LIMIT(MISS_LIMIT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .is_sync     (is_sync),
        .pos         (pos),
        .hits        (hits),
        .misses      (misses),
        .pos_step    (pos_step),
        .pos_restart (pos_restart),
        .pos_wrap_en (pos_wrap_en),
        .hit_clr     (hit_clr),
        .hit_load    (hit_load),
        .hit_inc     (hit_inc),
        .miss_clr    (miss_clr),
        .miss_inc    (miss_inc),
        .fwd         (fwd),
        .track_nxt   (track_nxt),
        .len_long_q  (len_long_q),
        .len_long_nxt(len_long_nxt)
    );

    tsf_pos_ctr #(.MAX_POS(LEN_LONG)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (pos_step),
        .restart(pos_restart),
        .wrap_en(pos_wrap_en),
        .wrap_at(wrap_at),
        .pos    (pos)
    );

    tsf_run_ctr #(.LIMIT(LOCK_HITS)) u_hits (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hit_clr),
        .load    (hit_load),
        .load_val(HIT_W'(2)),
        .inc     (hit_inc),
        .cnt     (hits)
    );

    tsf_run_ctr #(.LIMIT(MISS_LIMIT)) u_misses (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (miss_clr),
        .load    (1'b0),
        .load_val(MISS_W'(0)),
        .inc     (miss_inc),
        .cnt     (misses)
    );

    tsf_out_stage #(
        .LEN_SHORT(LEN_SHORT),
        .LEN_LONG (LEN_LONG),
        .SYNC_VAL (SYNC_VAL)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .fwd         (fwd),
        .byte_in     (in_byte),
        .pos         (pos),
        .track_nxt   (track_nxt),
        .len_long_nxt(len_long_nxt),
        .out_valid   (out_valid),
        .out_byte    (out_byte),
        .out_sop     (out_sop),
        .out_idx     (out_idx),
        .out_locked  (out_locked),
        .out_len     (out_len)
    );

    // An idle input cycle produces no output byte
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // An idle input cycle leaves the lock flag as it was
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_locked));
    // Lock clears right after reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_locked && !out_valid));
endmodule

// File: tb/ts_pkt_sync_bench.sv
// Self-checking bench: behavioural reference model compared every clock,
// plus directed checks at the lock, fallback and drop points.
module ts_pkt_sync_bench;
    localparam int LOCK = 3;
    localparam int MISS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid, out_sop, out_locked;
    logic [7:0] out_byte;
    logic [7:0] out_idx, out_len;

    int checks = 0;
    int failures = 0;
    bit gaps_on = 1'b0;
    int seed = 5;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ts_pkt_sync #(.LOCK_HITS(LOCK), .MISS_LIMIT(MISS)) u_ts_pkt_sync (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .out_sop(out_sop),
        .out_idx(out_idx), .out_locked(out_locked), .out_len(out_len)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_st, m_pos, m_len, m_hits, m_miss;
    bit e_valid, e_sop, e_locked;
    int e_byte, e_idx, e_len;

    always @(posedge clk) begin
        bit s;
        bit emit;
        int idx;
        if (!rst_n) begin
            m_st = 0; m_pos = 0; m_len = 188; m_hits = 0; m_miss = 0;
            e_valid = 0; e_locked = 0; e_len = 188; e_sop = 0; e_byte = 0; e_idx = 0;
        end else begin
            e_valid = 0;
            if (in_valid) begin
                s = (in_byte == 8'h47);
                idx = m_pos;
                emit = 0;
                case (m_st)
                    0: if (s) begin m_st = 1; m_pos = 1; end
                    1: begin
                        if (m_pos == 188 && s) begin
                            m_len = 188; m_hits = 2; m_st = 2; m_pos = 1;
                        end else if (m_pos == 204) begin
                            if (s) begin m_len = 204; m_hits = 2; m_st = 2; m_pos = 1; end
                            else m_st = 0;
                        end else m_pos++;
                    end
                    2: begin
                        if (m_pos == 0) begin
                            if (s) begin
                                m_hits++;
                                if (m_hits == LOCK) begin m_st = 3; m_miss = 0; emit = 1; end
                            end else m_st = 0;
                        end
                        m_pos = (m_pos == m_len - 1) ? 0 : m_pos + 1;
                    end
                    default: begin
                        emit = 1;
                        if (m_pos == 0) begin
                            if (s) m_miss = 0;
                            else begin
                                m_miss++;
                                if (m_miss == MISS) begin m_st = 0; emit = 0; end
                            end
                        end
                        m_pos = (m_pos == m_len - 1) ? 0 : m_pos + 1;
                    end
                endcase
                if (emit) begin
                    e_valid = 1; e_byte = in_byte; e_idx = idx; e_sop = (idx == 0);
                end
            end
            e_locked = (m_st == 3);
            e_len = m_len;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(e_locked ? "R8" : "R7", "out_valid", out_valid, e_valid);
            check("R5", "out_locked", out_locked, e_locked);
            if (e_locked) check(e_len == 204 ? "R3" : "R2", "out_len", out_len, e_len);
            if (e_valid && out_valid) begin
                check("R8", "out_byte", out_byte, e_byte);
                check("R8", "out_idx", out_idx, e_idx);
                check(e_sop ? "R9" : "R8", "out_sop", out_sop, e_sop);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            @(posedge clk); #1;
        end
    endtask

    task automatic put(input logic [7:0] b);
        if (gaps_on && ($urandom_range(0, 6) == 0)) idle(1);
        in_valid = 1'b1;
        in_byte = b;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic body(input int len);
        for (int i = 1; i < len; i++) begin
            logic [7:0] v;
            v = 8'(i * 13 + seed);
            if (v == 8'h47) v = 8'h46;
            put(v);
        end
        seed++;
    endtask

    task automatic pkt(input int len, input bit good);
        put(good ? 8'h47 : 8'hB8);
        body(len);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "out_locked after reset", out_locked, 0);
        check("R1", "out_valid after reset", out_valid, 0);
        rst_n = 1'b1;

        // junk without any sync value: nothing forwarded
        for (int i = 0; i < 60; i++) put(8'(i * 3 + 1) == 8'h47 ? 8'h00 : 8'(i * 3 + 1));
        check("R7", "locked on junk", out_locked, 0);

        gaps_on = 1'b1;
        // 188 pitch: lock on the third sync
        pkt(188, 1); pkt(188, 1);
        check("R5", "locked before third hit", out_locked, 0);
        put(8'h47);
        check("R5", "locked on third hit", out_locked, 1);
        check("R5", "first byte valid", out_valid, 1);
        check("R5", "first byte sop", out_sop, 1);
        check("R5", "first byte idx", out_idx, 0);
        check("R2", "length 188", out_len, 188);
        body(188);
        pkt(188, 1);

        // isolated misses below the limit keep lock
        pkt(188, 0); pkt(188, 0);
        check("R9", "locked after two misses", out_locked, 1);
        pkt(188, 1); pkt(188, 0); pkt(188, 1);
        check("R9", "locked after reset of miss run", out_locked, 1);

        // idle while locked
        idle(40);
        check("R11", "out_valid during idle", out_valid, 0);
        check("R11", "lock held during idle", out_locked, 1);

        // three consecutive misses drop lock
        pkt(188, 0); pkt(188, 0);
        put(8'hB8);
        check("R10", "lock dropped", out_locked, 0);
        check("R10", "dropping byte not forwarded", out_valid, 0);
        body(188);

        // 204 pitch
        pkt(204, 1); pkt(204, 1);
        put(8'h47);
        check("R3", "locked at 204", out_locked, 1);
        check("R3", "length 204", out_len, 204);
        body(204);
        pkt(204, 1); pkt(204, 1);
        pkt(204, 0); pkt(204, 0); pkt(204, 0);
        check("R10", "lock dropped at 204", out_locked, 0);

        // stray sync with no partner at either pitch
        put(8'h47);
        for (int i = 0; i < 260; i++) put(8'h11);
        pkt(188, 1); pkt(188, 1);
        put(8'h47);
        check("R4", "lock after stray sync released", out_locked, 1);
        body(188);
        pkt(188, 0); pkt(188, 0); pkt(188, 0);

        // a miss during confirmation restarts the count
        pkt(188, 1); pkt(188, 1); pkt(188, 0);
        check("R6", "no lock after confirm miss", out_locked, 0);
        pkt(188, 1);
        put(8'h47);
        check("R6", "still unlocked on second new hit", out_locked, 0);
        body(188);
        put(8'h47);
        check("R6", "locked on third new hit", out_locked, 1);
        body(188);
        pkt(188, 1);

        idle(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        failures++;
        $display("FAIL R8 watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule